// File: doc/BRIEF.md
# Serial Register Slave with Chain Selection

This block lets a host reach a bank of 8-bit control registers over a four-wire serial port (clock, active-low select, data in, data out). Every transfer carries a control byte and one data byte, most significant bit first. Bit 7 of the control byte asks for a read when it is 1, and bits 6:0 give the register address. The port clock idles high. The slave samples input data on rising port-clock edges and changes its output on falling edges. All port pins are sampled in the system clock domain, so the port clock must run well below the system clock.

When chain mode is on, several slaves can share one select line. Every transfer then opens with a selection byte, and a slave takes part only if the last bit of that byte is 1. The slave also copies its input data, one port-clock period late, to a pass-through output that feeds the next slave. A 16-bit indirect store sits behind a small group of direct registers. Writing an address to a trigger register posts a read or a write. A busy bit covers the request until it has been served a fixed number of system clocks later. Completion then raises a flag that the host clears by writing 1 to it.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset the data-out enable and the pass-through output are low. The configuration register (address 1) and the completion flag register (address 7) read 0x00.
- R2: A write transfer (control bit 7 = 0) stores its data byte at the address in control bits 6:0. A read transfer (bit 7 = 1) returns the register on data-out, MSB first, with each bit valid before the rising port-clock edge that ends it. Addresses 8 to NREG-1 are general storage.
- R3: Address 0 reads {2'b00, PART_ID[1:0], REV_ID[3:0]}, and writes to it have no effect.
- R4: These read as zero: configuration bits 5:0, status (address 6) bits 7:1, flag bits 7:1, both trigger addresses (4 and 5), and any address of NREG or above.
- R5: With configuration bit 6 = 0, data-out stays enabled after the last data bit until select is released. With bit 6 = 1, it is released at the rising port-clock edge of the last (LSB) data bit.
- R6: Data-out is enabled only during the data byte of a read, and never while select is high.
- R7: With configuration bit 7 = 1, the first byte of a transfer is a selection byte. If its LSB is 0, the slave ignores the rest of the transfer: no register changes and data-out is never enabled.
- R8: In chain mode, after each rising port-clock edge the pass-through output shows the input bit sampled at the rising edge before it. It shows 0 after the first edge of a transfer. With chain mode off, it stays 0.
- R9: Writing an indirect address to address 4 posts a write of {address 3, address 2} to that location. Status bit 0 (address 6) reads 1 from the request until it is served, SVC_CYC system clocks later.
- R10: Writing an indirect address to address 5 posts a read. Once it is served, addresses 3 and 2 hold the high and low bytes of the stored word.
- R11: Flag bit 0 (address 7) is set when an indirect request completes. Writing a 1 to it clears it, and writing a 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Port clock, idles high |
| spi_cs_n | input | 1 | Active-low select |
| spi_sdi | input | 1 | Serial data from host |
| spi_sdo | output | 1 | Serial data to host |
| spi_sdo_oe | output | 1 | Output enable for spi_sdo (1 = drive) |
| spi_pass | output | 1 | Delayed copy of spi_sdi for the next slave in a chain |

## Verification
Bit-counter or phase faults show up within the same transfer. Read data comes back shifted, data-out is enabled during a write, or a chain slave that is not selected still takes a write. The next read-back of any register exposes these errors. A fault in the indirect engine leaves the busy bit stuck or the flag unset, and either one is visible on the first status read after SVC_CYC clocks. A wrong memory port shows as the wrong word in the data registers after an indirect read. Release-point and pass-through faults are seen at the port-clock edge itself, a few system clocks after it.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  typedef enum logic [1:0] {PH_SEL, PH_CTRL, PH_DATA, PH_SKIP} phase_t;

  localparam logic [6:0] A_ID    = 7'd0;
  localparam logic [6:0] A_CFG   = 7'd1;
  localparam logic [6:0] A_IDLO  = 7'd2;
  localparam logic [6:0] A_IDHI  = 7'd3;
  localparam logic [6:0] A_IWADR = 7'd4;
  localparam logic [6:0] A_IRADR = 7'd5;
  localparam logic [6:0] A_STAT  = 7'd6;
  localparam logic [6:0] A_FLAG  = 7'd7;
  localparam logic [6:0] A_SCR0  = 7'd8;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= RST_VAL[g];
        s2 <= RST_VAL[g];
      end else begin
        s1 <= d_in[g];
        s2 <= s1;
      end
    end
    assign q[g] = s2;
  end
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sclk_s,
  input  logic       csn_s,
  input  logic       sdi_s,
  input  logic       chain_en,
  input  logic       early_rel,
  input  logic [7:0] rd_byte,
  output logic [6:0] addr,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       is_read,
  output logic       sdo,
  output logic       sdo_oe,
  output logic       pass_out
);
  logic       sclk_d, csn_d, prev_bit, load;
  logic [2:0] cnt;
  logic [7:0] sh, tx;
  phase_t     phase;

  wire sclk_rise = sclk_s & ~sclk_d;
  wire sclk_fall = ~sclk_s & sclk_d;
  wire start     = ~csn_s & csn_d;
  wire stop      = csn_s & ~csn_d;
  wire active    = ~csn_s;
  wire [7:0] nxt = {sh[6:0], sdi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b1;
      csn_d    <= 1'b1;
      prev_bit <= 1'b0;
      load     <= 1'b0;
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      phase    <= PH_SKIP;
      addr     <= '0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
      is_read  <= 1'b0;
      sdo      <= 1'b0;
      sdo_oe   <= 1'b0;
      pass_out <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
      wr_en  <= 1'b0;
      load   <= 1'b0;
      if (load) tx <= rd_byte;
      if (start) begin
        phase    <= chain_en ? PH_SEL : PH_CTRL;
        cnt      <= '0;
        prev_bit <= 1'b0;
        pass_out <= 1'b0;
        is_read  <= 1'b0;
      end else if (stop) begin
        sdo_oe   <= 1'b0;
        phase    <= PH_SKIP;
        pass_out <= 1'b0;
      end else if (active && sclk_rise) begin
        sh  <= nxt;
        cnt <= cnt + 3'd1;
        if (chain_en) begin
          pass_out <= prev_bit;
          prev_bit <= sdi_s;
        end
        if (cnt == 3'd7) begin
          unique case (phase)
            PH_SEL:  phase <= sdi_s ? PH_CTRL : PH_SKIP;
            PH_CTRL: begin
              is_read <= nxt[7];
              addr    <= nxt[6:0];
              load    <= nxt[7];
              phase   <= PH_DATA;
            end
            PH_DATA: begin
              wr_en   <= ~is_read;
              wr_data <= nxt;
              phase   <= PH_SKIP;
              if (early_rel) sdo_oe <= 1'b0;
            end
            default: phase <= PH_SKIP;
          endcase
        end
      end else if (active && sclk_fall && phase == PH_DATA && is_read) begin
        sdo    <= tx[7];
        tx     <= {tx[6:0], 1'b0};
        sdo_oe <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_ind_engine.sv
module spi_ind_engine #(
  parameter int AW      = 8,
  parameter int DW      = 16,
  parameter int SVC_CYC = 800
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          done,
  output logic          done_rd,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(SVC_CYC + 1);

  logic [DW-1:0] mem [0:DEPTH-1];
  logic [AW-1:0] a_l;
  logic [DW-1:0] d_l;
  logic          op_wr;
  logic [CW-1:0] cnt;

  wire last = busy && (cnt == CW'(SVC_CYC - 1));
  wire we   = last && op_wr;

  always_ff @(posedge clk) begin
    if (we) mem[a_l] <= d_l;
    rdata <= mem[a_l];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      done_rd <= 1'b0;
      a_l     <= '0;
      d_l     <= '0;
      op_wr   <= 1'b0;
      cnt     <= '0;
    end else begin
      done    <= 1'b0;
      done_rd <= 1'b0;
      if (!busy && (wr_req || rd_req)) begin
        busy  <= 1'b1;
        cnt   <= '0;
        a_l   <= req_addr;
        d_l   <= wdata;
        op_wr <= wr_req;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (last) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          done_rd <= ~op_wr;
        end
      end
    end
  end
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
  import spi_reg_pkg::*;
#(
  parameter int         NREG   = 16,
  parameter logic [1:0] PART_ID = 2'b01,
  parameter logic [3:0] REV_ID  = 4'h3,
  parameter int         IND_AW  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [6:0]        addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic              done,
  input  logic              done_rd,
  input  logic [15:0]       ind_rdata,
  output logic [7:0]        rd_byte,
  output logic              chain_en,
  output logic              early_rel,
  output logic              ind_wr,
  output logic              ind_rd,
  output logic [IND_AW-1:0] ind_addr,
  output logic [15:0]       ind_wdata,
  output logic              done_flag
);
  localparam int NSCR = NREG - int'(A_SCR0);
  localparam int SW   = (NSCR > 1) ? $clog2(NSCR) : 1;

  logic [7:0] scr [0:NSCR-1];
  logic [7:0] idlo, idhi;

  wire [6:0] off    = addr - A_SCR0;
  wire       in_scr = (addr >= A_SCR0) && (int'(addr) < NREG);

  assign ind_wr    = wr_en && addr == A_IWADR;
  assign ind_rd    = wr_en && addr == A_IRADR;
  assign ind_addr  = wr_data[IND_AW-1:0];
  assign ind_wdata = {idhi, idlo};

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_en  <= 1'b0;
      early_rel <= 1'b0;
      idlo      <= '0;
      idhi      <= '0;
      done_flag <= 1'b0;
      for (int i = 0; i < NSCR; i++) scr[i] <= '0;
    end else begin
      if (wr_en && addr == A_CFG) begin
        chain_en  <= wr_data[7];
        early_rel <= wr_data[6];
      end
      if (done && done_rd) begin
        idlo <= ind_rdata[7:0];
        idhi <= ind_rdata[15:8];
      end else begin
        if (wr_en && addr == A_IDLO) idlo <= wr_data;
        if (wr_en && addr == A_IDHI) idhi <= wr_data;
      end
      if (done) done_flag <= 1'b1;
      else if (wr_en && addr == A_FLAG && wr_data[0]) done_flag <= 1'b0;
      if (wr_en && in_scr) scr[off[SW-1:0]] <= wr_data;
    end
  end

  always_comb begin
    rd_byte = '0;
    case (addr)
      A_ID:    rd_byte = {2'b00, PART_ID, REV_ID};
      A_CFG:   rd_byte = {chain_en, early_rel, 6'b0};
      A_IDLO:  rd_byte = idlo;
      A_IDHI:  rd_byte = idhi;
      A_STAT:  rd_byte = {7'b0, busy};
      A_FLAG:  rd_byte = {7'b0, done_flag};
      default: if (in_scr) rd_byte = scr[off[SW-1:0]];
    endcase
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int         NREG    = 16,
  parameter logic [1:0] PART_ID = 2'b01,
  parameter logic [3:0] REV_ID  = 4'h3,
  parameter int         IND_AW  = 8,
  parameter int         SVC_CYC = 800
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_sdi,
  output logic spi_sdo,
  output logic spi_sdo_oe,
  output logic spi_pass
);
  logic [2:0]        pins_s;
  logic              sclk_s, csn_s, sdi_s;
  logic [6:0]        wr_addr;
  logic              wr_en, is_read;
  logic [7:0]        wr_data, rd_byte;
  logic              chain_en, early_rel;
  logic              ind_wr, ind_rd, eng_busy, eng_done, eng_done_rd, done_flag;
  logic [IND_AW-1:0] ind_addr;
  logic [15:0]       ind_wdata, ind_rdata;

  spi_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst(rst), .d_in({spi_sclk, spi_cs_n, spi_sdi}), .q(pins_s)
  );
  assign {sclk_s, csn_s, sdi_s} = pins_s;

  spi_frame u_frame (
    .clk(clk), .rst(rst), .sclk_s(sclk_s), .csn_s(csn_s), .sdi_s(sdi_s),
    .chain_en(chain_en), .early_rel(early_rel), .rd_byte(rd_byte),
    .addr(wr_addr), .wr_en(wr_en), .wr_data(wr_data), .is_read(is_read),
    .sdo(spi_sdo), .sdo_oe(spi_sdo_oe), .pass_out(spi_pass)
  );

  spi_regfile #(.NREG(NREG), .PART_ID(PART_ID), .REV_ID(REV_ID), .IND_AW(IND_AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(wr_addr), .wr_data(wr_data),
    .busy(eng_busy), .done(eng_done), .done_rd(eng_done_rd), .ind_rdata(ind_rdata),
    .rd_byte(rd_byte), .chain_en(chain_en), .early_rel(early_rel),
    .ind_wr(ind_wr), .ind_rd(ind_rd), .ind_addr(ind_addr), .ind_wdata(ind_wdata),
    .done_flag(done_flag)
  );

  spi_ind_engine #(.AW(IND_AW), .DW(16), .SVC_CYC(SVC_CYC)) u_eng (
    .clk(clk), .rst(rst), .wr_req(ind_wr), .rd_req(ind_rd), .req_addr(ind_addr),
    .wdata(ind_wdata), .busy(eng_busy), .done(eng_done), .done_rd(eng_done_rd),
    .rdata(ind_rdata)
  );
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
  parameter int SVC_CYC = 800
) (
  input logic       clk,
  input logic       rst,
  input logic       spi_cs_n,
  input logic       spi_sdo_oe,
  input logic       is_read,
  input logic       eng_busy,
  input logic       done_flag,
  input logic       wr_en,
  input logic [6:0] wr_addr,
  input logic       wr_bit0
);
  logic [31:0] busy_len;

  always_ff @(posedge clk) begin
    if (rst) busy_len <= '0;
    else if (eng_busy) busy_len <= busy_len + 1;
    else busy_len <= '0;
  end

  AST_SDO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3) && $past(spi_cs_n, 4))
      |-> !spi_sdo_oe); // R6

  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
    spi_sdo_oe |-> is_read); // R6

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy_len <= 32'(SVC_CYC)); // R9

  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    $fell(eng_busy) |=> done_flag); // R11

  AST_FLAG_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(done_flag) |-> $past(wr_en && wr_addr == 7'd7 && wr_bit0)); // R11
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.SVC_CYC(SVC_CYC)) u_chk (
  .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sdo_oe(spi_sdo_oe),
  .is_read(is_read), .eng_busy(eng_busy), .done_flag(done_flag),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit0(wr_data[0])
);

// File: tb/spi_reg_slave_test.sv
`timescale 1ns/1ps
module spi_reg_slave_test;
  localparam logic [1:0] PART = 2'b01;
  localparam logic [3:0] REV  = 4'h3;
  localparam int SVC = 800;
  localparam int H   = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sclk = 1'b1, spi_cs_n = 1'b1, spi_sdi = 1'b0;
  logic spi_sdo, spi_sdo_oe, spi_pass;
  int checks = 0, errors = 0;
  logic chain_on = 1'b0;
  logic [7:0] sel_val = 8'h01;
  logic [7:0] last_pass;
  logic last_oe_any, last_oe_end, last_oe_after;

  always #2.5 clk = ~clk;

  spi_reg_slave #(.NREG(16), .PART_ID(PART), .REV_ID(REV), .IND_AW(8), .SVC_CYC(SVC)) uut (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_sdi(spi_sdi),
    .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe), .spi_pass(spi_pass)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic shift_byte(input logic [7:0] tx, output logic [7:0] rx,
                            output logic [7:0] pseen, inout logic oe_any, output logic oe_last);
    for (int i = 7; i >= 0; i--) begin
      spi_sclk = 1'b0;
      spi_sdi  = tx[i];
      wait_clk(H);
      rx[i] = spi_sdo;
      oe_any |= spi_sdo_oe;
      spi_sclk = 1'b1;
      wait_clk(H);
      pseen[i] = spi_pass;
      oe_any |= spi_sdo_oe;
      oe_last = spi_sdo_oe;
    end
  endtask

  task automatic xfer(input logic rd, input logic [6:0] a, input logic [7:0] d,
                      output logic [7:0] rx);
    logic [7:0] dummy, p;
    logic oe_any, oe_last;
    oe_any = 1'b0;
    spi_cs_n = 1'b0;
    wait_clk(H);
    if (chain_on) shift_byte(sel_val, dummy, last_pass, oe_any, oe_last);
    shift_byte({rd, a}, dummy, p, oe_any, oe_last);
    if (!chain_on) last_pass = p;
    shift_byte(rd ? 8'h00 : d, rx, p, oe_any, oe_last);
    last_oe_end = oe_last;
    spi_cs_n = 1'b1;
    wait_clk(H);
    last_oe_after = spi_sdo_oe;
    last_oe_any = oe_any;
    wait_clk(H);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] r;
    xfer(1'b0, a, d, r);
  endtask

  task automatic rdreg(input logic [6:0] a, output logic [7:0] d);
    xfer(1'b1, a, 8'h00, d);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 oe after reset", {15'b0, spi_sdo_oe}, 16'h0);
    chk("R1 pass after reset", {15'b0, spi_pass}, 16'h0);
    rdreg(7'd1, v); chk("R1 cfg reset", {8'h0, v}, 16'h0000);
    rdreg(7'd7, v); chk("R1 flag reset", {8'h0, v}, 16'h0000);
  endtask

  task automatic t_storage;
    logic [7:0] v;
    wr(7'd8, 8'hA5);
    chk("R6 no drive during write", {15'b0, last_oe_any}, 16'h0);
    wr(7'd15, 8'h3C);
    rdreg(7'd8, v);  chk("R2 readback addr 8", {8'h0, v}, 16'h00A5);
    rdreg(7'd15, v); chk("R2 readback addr 15", {8'h0, v}, 16'h003C);
    chk("R6 released after select high", {15'b0, last_oe_after}, 16'h0);
  endtask

  task automatic t_id;
    logic [7:0] v;
    rdreg(7'd0, v); chk("R3 id value", {8'h0, v}, {8'h0, 2'b00, PART, REV});
    wr(7'd0, 8'hFF);
    rdreg(7'd0, v); chk("R3 id after write", {8'h0, v}, {8'h0, 2'b00, PART, REV});
  endtask

  task automatic t_reserved;
    logic [7:0] v;
    wr(7'd1, 8'h3F);
    rdreg(7'd1, v); chk("R4 cfg low bits", {8'h0, v}, 16'h0000);
    wr(7'd6, 8'hFF);
    rdreg(7'd6, v); chk("R4 status high bits", {8'h0, v}, 16'h0000);
    rdreg(7'd20, v); chk("R4 unmapped address", {8'h0, v}, 16'h0000);
    rdreg(7'd4, v); chk("R4 trigger address", {8'h0, v}, 16'h0000);
  endtask

  task automatic t_release;
    logic [7:0] v;
    rdreg(7'd8, v);
    chk("R5 normal holds after LSB", {15'b0, last_oe_end}, 16'h1);
    chk("R5 normal drops at select high", {15'b0, last_oe_after}, 16'h0);
    wr(7'd1, 8'h40);
    rdreg(7'd8, v);
    chk("R5 early data", {8'h0, v}, 16'h00A5);
    chk("R5 early release at LSB edge", {15'b0, last_oe_end}, 16'h0);
    wr(7'd1, 8'h00);
  endtask

  task automatic t_chain;
    logic [7:0] v;
    wr(7'd1, 8'h80);
    chain_on = 1'b1;
    sel_val = 8'hB5;
    wr(7'd9, 8'h5E);
    chk("R8 pass during select byte", {8'h0, last_pass}, {8'h0, 1'b0, 8'hB5 >> 1});
    sel_val = 8'h03;
    rdreg(7'd9, v); chk("R7 selected readback", {8'h0, v}, 16'h005E);
    sel_val = 8'h02;
    wr(7'd9, 8'hEE);
    rdreg(7'd9, v);
    chk("R7 unselected no drive", {15'b0, last_oe_any}, 16'h0);
    sel_val = 8'h01;
    rdreg(7'd9, v); chk("R7 unselected write ignored", {8'h0, v}, 16'h005E);
    wr(7'd1, 8'h00);
    chain_on = 1'b0;
    wr(7'd10, 8'hFF);
    chk("R8 pass low without chain", {8'h0, last_pass}, 16'h0000);
  endtask

  task automatic t_indirect;
    logic [7:0] v, lo, hi;
    wr(7'd2, 8'h34);
    wr(7'd3, 8'h12);
    wr(7'd4, 8'h5A);
    rdreg(7'd6, v); chk("R9 busy while pending", {8'h0, v}, 16'h0001);
    wait_clk(SVC + 50);
    rdreg(7'd6, v); chk("R9 busy cleared", {8'h0, v}, 16'h0000);
    rdreg(7'd7, v); chk("R11 flag set", {8'h0, v}, 16'h0001);
    wr(7'd7, 8'h00);
    rdreg(7'd7, v); chk("R11 write 0 keeps flag", {8'h0, v}, 16'h0001);
    wr(7'd7, 8'h01);
    rdreg(7'd7, v); chk("R11 write 1 clears", {8'h0, v}, 16'h0000);
    wr(7'd2, 8'hEF);
    wr(7'd3, 8'hBE);
    wr(7'd4, 8'h07);
    wait_clk(SVC + 50);
    wr(7'd2, 8'h00);
    wr(7'd3, 8'h00);
    wr(7'd5, 8'h5A);
    wait_clk(SVC + 50);
    rdreg(7'd2, lo); rdreg(7'd3, hi);
    chk("R10 read back 0x5A", {hi, lo}, 16'h1234);
    wr(7'd5, 8'h07);
    wait_clk(SVC + 50);
    rdreg(7'd2, lo); rdreg(7'd3, hi);
    chk("R10 read back 0x07", {hi, lo}, 16'hBEEF);
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    t_reset;
    t_storage;
    t_id;
    t_reserved;
    t_release;
    t_chain;
    t_indirect;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule